// File: doc/BRIEF.md
# High-Block Program/Erase Protection Register Bank

This block holds the program and erase protection state for six high-address flash blocks. It sits behind a single-cycle synchronous register port and answers program or erase requests from the flash controller with a one-cycle grant or error pulse. Each block has two protection bits: a primary bit and a secondary bit. A block is protected while either bit is set.

The primary bits are guarded by a key. Software can change them only after it has written a fixed 32-bit key word to the primary register. That unlock stays in force until the next reset. Software cannot read the unlock flag back as zero once it is set, and it cannot write the flag. The secondary bits need no key. After reset, both sets of bits take their starting values from shadow nonvolatile inputs. An erased shadow (all ones) leaves every block protected.

The reset input is asserted asynchronously and released through a synchroniser. The shadow values are loaded on the first clock after that release. Until then, every block reads as protected.

Top module: `hiblk_lock_ctrl`

## Requirements
- R1: While reset is asserted and right after it, the unlock flag is 0, `reg_rdata` is 0, and neither `op_grant` nor `op_err` is asserted.
- R2: Writing exactly 0xB2B2_2222 to word address 0 sets the unlock flag. The flag then stays 1 until reset, whatever is written afterwards. The same word written to any other address does not set it.
- R3: While the unlock flag is 0, writes to the primary field at word address 0 change nothing. A wrong key has no lasting effect, and a later correct key still unlocks.
- R4: A write of the key word never changes the primary field, even when the flag is already 1.
- R5: On the third rising clock edge after `rst_n` rises, the primary bits load `shadow_prim` and the secondary bits load `shadow_sec`. Before that edge, all bits of `blk_locked` read 1. A shadow value of all ones therefore leaves every block locked.
- R6: Word address 0 reads as {flag at bit 31, zeros in bits 30:6, primary field in bits 5:0}. Word address 1 reads as {zeros in bits 31:6, secondary field in bits 5:0}. Any write to address 1 loads bits 5:0 into the secondary field, with no key needed.
- R7: `blk_locked[i]` equals primary bit i OR secondary bit i, where bit i belongs to block i.
- R8: A request (`op_req`=1) for block index `op_blk` is answered on the next cycle by a one-cycle pulse. The pulse is `op_err` if that block's effective lock is 1 or if `op_blk` ≥ 6. Otherwise it is `op_grant`. The two pulses are never asserted together, and neither is asserted without a request.
- R9: A read (`reg_rd_en`=1) puts the register contents from before any write in the same cycle on `reg_rdata` one cycle later. `reg_rdata` holds its value until the next read. Addresses other than 0 and 1 read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 4 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid one cycle after a read |
| shadow_prim | input | 6 | Shadow starting values for the primary bits |
| shadow_sec | input | 6 | Shadow starting values for the secondary bits |
| op_req | input | 1 | Program or erase request strobe |
| op_blk | input | 3 | Target block index of the request |
| op_grant | output | 1 | One-cycle pulse: request accepted |
| op_err | output | 1 | One-cycle pulse: request refused |
| blk_locked | output | 6 | Effective per-block protection |

## Verification
The gating is tested in a fixed order: primary writes with no key, a key that differs from the true one in a single bit, the true key, writes after unlocking, and a repeated key. Each result is read back. This order separates the cases "write ignored", "locked out", "unlocked" and "key leaked into the field". Two resets with different shadow patterns are used. One is mixed and one is fully erased. Together they show that the loaded values really come from the shadow inputs and that the flag is cleared. Requests to unlocked blocks, locked blocks and out-of-range indices show which of the two OR inputs causes a refusal. A long random phase mixes key hits, misses and unmapped accesses, and a behavioural model checks it on every clock.

// File: rtl/hiblk_lock_pkg.sv
package hiblk_lock_pkg;

  localparam int unsigned REG_W = 32;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_PRIM = 2'd1,
    SEL_SEC  = 2'd2
  } reg_sel_e;

endpackage

// File: rtl/hiblk_rst_sync.sv
module hiblk_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/hiblk_key_gate.sv
module hiblk_key_gate
  import hiblk_lock_pkg::*;
#(
  parameter logic [REG_W-1:0] UNLOCK_KEY = 32'hB2B2_2222
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prim_wr,
  input  logic [REG_W-1:0] wdata,
  output logic             key_hit,
  output logic             unlocked
);

  logic unlocked_q;
  logic unlocked_d;

  assign key_hit = prim_wr && (wdata == UNLOCK_KEY);

  always_comb begin
    unlocked_d = unlocked_q;
    if (key_hit) unlocked_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) unlocked_q <= 1'b0;
    else        unlocked_q <= unlocked_d;
  end

  assign unlocked = unlocked_q;

  // R2: once set, the flag survives every later write
  assert_flag_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    unlocked_q |=> unlocked_q);

  // R2: the flag only rises after a key write to the primary word
  assert_flag_rise_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked_q) |-> $past(prim_wr && (wdata == UNLOCK_KEY)));

endmodule

// File: rtl/hiblk_lock_bank.sv
module hiblk_lock_bank #(
  parameter int unsigned NUM_BLK = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_BLK-1:0] shadow_prim,
  input  logic [NUM_BLK-1:0] shadow_sec,
  input  logic               prim_wr,
  input  logic               sec_wr,
  input  logic               key_hit,
  input  logic               unlocked,
  input  logic [NUM_BLK-1:0] wfield,
  output logic [NUM_BLK-1:0] prim_q,
  output logic [NUM_BLK-1:0] sec_q,
  output logic [NUM_BLK-1:0] eff_lock
);

  logic booting_q;
  logic booting_d;
  logic prim_en;

  assign booting_d = 1'b0;
  assign prim_en   = prim_wr && unlocked && !key_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) booting_q <= 1'b1;
    else        booting_q <= booting_d;
  end

  for (genvar g = 0; g < NUM_BLK; g++) begin : g_blk
    logic p_d;
    logic s_d;

    always_comb begin
      p_d = prim_q[g];
      if (booting_q)    p_d = shadow_prim[g];
      else if (prim_en) p_d = wfield[g];
    end

    always_comb begin
      s_d = sec_q[g];
      if (booting_q)   s_d = shadow_sec[g];
      else if (sec_wr) s_d = wfield[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prim_q[g] <= 1'b1;
        sec_q[g]  <= 1'b1;
      end else begin
        prim_q[g] <= p_d;
        sec_q[g]  <= s_d;
      end
    end

    assign eff_lock[g] = prim_q[g] | sec_q[g];
  end

  // R3: without the unlock flag the primary field cannot move
  assert_locked_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!booting_q && !unlocked) |=> $stable(prim_q));

  // R4: the key word is never stored into the primary field
  assert_key_not_stored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!booting_q && key_hit) |=> $stable(prim_q));

  // R5: the boot cycle loads both fields from shadow
  assert_boot_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    booting_q |=> (prim_q == $past(shadow_prim)) && (sec_q == $past(shadow_sec)));

endmodule

// File: rtl/hiblk_op_check.sv
module hiblk_op_check #(
  parameter int unsigned NUM_BLK = 6,
  parameter int unsigned IDX_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req,
  input  logic [IDX_W-1:0]   blk_idx,
  input  logic [NUM_BLK-1:0] eff_lock,
  output logic               grant,
  output logic               err
);

  logic sel_locked;
  logic grant_d, err_d;
  logic grant_q, err_q;

  always_comb begin
    sel_locked = 1'b1;
    for (int i = 0; i < NUM_BLK; i++) begin
      if (blk_idx == IDX_W'(i)) sel_locked = eff_lock[i];
    end
  end

  always_comb begin
    grant_d = req && !sel_locked;
    err_d   = req && sel_locked;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      grant_q <= grant_d;
      err_q   <= err_d;
    end
  end

  assign grant = grant_q;
  assign err   = err_q;

  // R8: grant and error never together
  assert_resp_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({grant_q, err_q}));

  // R8: no response without a request
  assert_no_spurious_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !grant_q && !err_q);

  // R8: when everything is locked every request is refused
  assert_all_locked_refused_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req && (&eff_lock)) |=> err_q && !grant_q);

  // R8: indices beyond the last block are refused
  assert_range_refused_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req && (32'(blk_idx) >= NUM_BLK)) |=> err_q);

endmodule

// File: rtl/hiblk_rd_path.sv
module hiblk_rd_path
  import hiblk_lock_pkg::*;
#(
  parameter int unsigned NUM_BLK = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_en,
  input  reg_sel_e           sel,
  input  logic               unlocked,
  input  logic [NUM_BLK-1:0] prim_q,
  input  logic [NUM_BLK-1:0] sec_q,
  output logic [REG_W-1:0]   rdata
);

  localparam int unsigned PAD_PRIM = REG_W - 1 - NUM_BLK;
  localparam int unsigned PAD_SEC  = REG_W - NUM_BLK;

  logic [REG_W-1:0] word;
  logic [REG_W-1:0] rdata_d;
  logic [REG_W-1:0] rdata_q;

  always_comb begin
    unique case (sel)
      SEL_PRIM: word = {unlocked, {PAD_PRIM{1'b0}}, prim_q};
      SEL_SEC:  word = {{PAD_SEC{1'b0}}, sec_q};
      default:  word = '0;
    endcase
  end

  always_comb begin
    rdata_d = rdata_q;
    if (rd_en) rdata_d = word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;

  // R9: unmapped reads return zero
  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel == SEL_NONE) |=> rdata_q == '0);

  // R9: read data holds between reads
  assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata_q));

  // R6: secondary word never shows bits above the field
  assert_sec_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel == SEL_SEC) |=> rdata_q[REG_W-1:NUM_BLK] == '0);

endmodule

// File: rtl/hiblk_lock_ctrl.sv
module hiblk_lock_ctrl
  import hiblk_lock_pkg::*;
#(
  parameter int unsigned      NUM_BLK     = 6,
  parameter int unsigned      ADDR_W      = 4,
  parameter int unsigned      SYNC_STAGES = 2,
  parameter logic [REG_W-1:0] UNLOCK_KEY  = 32'hB2B2_2222,
  parameter logic [ADDR_W-1:0] PRIM_ADDR  = '0,
  parameter logic [ADDR_W-1:0] SEC_ADDR   = ADDR_W'(1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_wr_en,
  input  logic                       reg_rd_en,
  input  logic [ADDR_W-1:0]          reg_addr,
  input  logic [REG_W-1:0]           reg_wdata,
  output logic [REG_W-1:0]           reg_rdata,
  input  logic [NUM_BLK-1:0]         shadow_prim,
  input  logic [NUM_BLK-1:0]         shadow_sec,
  input  logic                       op_req,
  input  logic [$clog2(NUM_BLK)-1:0] op_blk,
  output logic                       op_grant,
  output logic                       op_err,
  output logic [NUM_BLK-1:0]         blk_locked
);

  localparam int unsigned IDX_W = $clog2(NUM_BLK);

  logic               rst_n_sync;
  reg_sel_e           sel;
  logic               prim_wr, sec_wr;
  logic               key_hit, unlocked;
  logic [NUM_BLK-1:0] prim_q, sec_q, eff_lock;

  always_comb begin
    if (reg_addr == PRIM_ADDR)     sel = SEL_PRIM;
    else if (reg_addr == SEC_ADDR) sel = SEL_SEC;
    else                           sel = SEL_NONE;
  end

  assign prim_wr = reg_wr_en && (sel == SEL_PRIM);
  assign sec_wr  = reg_wr_en && (sel == SEL_SEC);

  hiblk_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  hiblk_key_gate #(.UNLOCK_KEY(UNLOCK_KEY)) u_key_gate (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .prim_wr  (prim_wr),
    .wdata    (reg_wdata),
    .key_hit  (key_hit),
    .unlocked (unlocked)
  );

  hiblk_lock_bank #(.NUM_BLK(NUM_BLK)) u_lock_bank (
    .clk         (clk),
    .rst_n       (rst_n_sync),
    .shadow_prim (shadow_prim),
    .shadow_sec  (shadow_sec),
    .prim_wr     (prim_wr),
    .sec_wr      (sec_wr),
    .key_hit     (key_hit),
    .unlocked    (unlocked),
    .wfield      (reg_wdata[NUM_BLK-1:0]),
    .prim_q      (prim_q),
    .sec_q       (sec_q),
    .eff_lock    (eff_lock)
  );

  hiblk_op_check #(.NUM_BLK(NUM_BLK), .IDX_W(IDX_W)) u_op_check (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .req      (op_req),
    .blk_idx  (op_blk),
    .eff_lock (eff_lock),
    .grant    (op_grant),
    .err      (op_err)
  );

  hiblk_rd_path #(.NUM_BLK(NUM_BLK)) u_rd_path (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .rd_en    (reg_rd_en),
    .sel      (sel),
    .unlocked (unlocked),
    .prim_q   (prim_q),
    .sec_q    (sec_q),
    .rdata    (reg_rdata)
  );

  assign blk_locked = eff_lock;

  // R7: a set primary or secondary bit always shows as locked
  assert_eff_covers_R7: assert property (@(posedge clk) disable iff (!rst_n_sync)
    ((prim_q | sec_q) & ~blk_locked) == '0);

  // R1: during reset no response pulses appear
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n_sync |-> !op_grant && !op_err && reg_rdata == '0);

endmodule

// File: tb/test_hiblk_lock_ctrl.sv
`timescale 1ns/1ps
module test_hiblk_lock_ctrl;

  localparam logic [31:0] KEY = 32'hB2B2_2222;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0, rd = 1'b0, req = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [5:0]  sp = '1, ss = '1;
  logic [2:0]  blk = '0;
  logic [31:0] rdata;
  logic        grant, err;
  logic [5:0]  locked;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  bit model_on = 0;
  bit m_flag, m_grant, m_err;
  logic [5:0]  m_prim, m_sec;
  logic [31:0] m_rdata;

  always #2.5 clk = ~clk;

  hiblk_lock_ctrl i_hiblk_lock_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(wr), .reg_rd_en(rd), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .shadow_prim(sp), .shadow_sec(ss),
    .op_req(req), .op_blk(blk), .op_grant(grant), .op_err(err), .blk_locked(locked)
  );

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", rq, act, exp, $time);
    end
  endtask

  // reference model: responses from old state, then state update
  always @(posedge clk) begin
    if (model_on) begin
      logic [5:0] eff;
      bit lk;
      eff = m_prim | m_sec;
      if (rd) begin
        if (addr == 4'd0)      m_rdata = {m_flag, 25'd0, m_prim};
        else if (addr == 4'd1) m_rdata = {26'd0, m_sec};
        else                   m_rdata = 32'd0;
      end
      m_grant = 0; m_err = 0;
      if (req) begin
        lk = (blk >= 3'd6) ? 1'b1 : eff[blk];
        m_err = lk; m_grant = !lk;
      end
      if (wr && addr == 4'd0) begin
        if (wdata == KEY) m_flag = 1;
        else if (m_flag)  m_prim = wdata[5:0];
      end
      if (wr && addr == 4'd1) m_sec = wdata[5:0];
    end
  end

  always @(negedge clk) begin
    if (model_on) begin
      chk(locked === (m_prim | m_sec), "R7 blk_locked", 32'(locked), 32'(m_prim | m_sec));
      chk({grant, err} === {m_grant, m_err}, "R8 grant/err", 32'({grant, err}), 32'({m_grant, m_err}));
      chk(rdata === m_rdata, "R9 rdata", rdata, m_rdata);
    end
  end

  task automatic drive(input bit w, input bit r, input logic [3:0] a, input logic [31:0] d,
                       input bit q, input logic [2:0] b);
    @(negedge clk);
    wr = w; rd = r; addr = a; wdata = d; req = q; blk = b;
  endtask

  task automatic idle();
    drive(0, 0, 4'd0, 32'd0, 0, 3'd0);
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    drive(1, 0, a, d, 0, 3'd0);
  endtask

  task automatic rd_expect(input logic [3:0] a, input logic [31:0] e, input string rq);
    drive(0, 1, a, 32'd0, 0, 3'd0);
    idle();
    chk(rdata === e, rq, rdata, e);
  endtask

  task automatic op_expect(input logic [2:0] b, input bit exp_grant, input string rq);
    drive(0, 0, 4'd0, 32'd0, 1, b);
    idle();
    chk({grant, err} === {exp_grant, !exp_grant}, rq, 32'({grant, err}), 32'({exp_grant, !exp_grant}));
  endtask

  task automatic do_reset(input logic [5:0] p, input logic [5:0] s);
    @(negedge clk);
    model_on = 0; rst_n = 0; sp = p; ss = s;
    wr = 0; rd = 0; req = 0; addr = '0; wdata = '0; blk = '0;
    repeat (3) @(negedge clk);
    chk(rdata === 32'd0, "R1 rdata in reset", rdata, 32'd0);
    chk({grant, err} === 2'b00, "R1 no pulses in reset", 32'({grant, err}), 32'd0);
    chk(locked === 6'h3F, "R5 all locked in reset", 32'(locked), 32'h3F);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(locked === 6'h3F, "R5 locked before load", 32'(locked), 32'h3F);
    @(negedge clk);
    chk(locked === (p | s), "R5 shadow loaded", 32'(locked), 32'(p | s));
    #1;
    m_flag = 0; m_prim = p; m_sec = s; m_rdata = '0; m_grant = 0; m_err = 0;
    model_on = 1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset(6'b101001, 6'b000110);
    rd_expect(4'd0, 32'h0000_0029, "R1 R5 R6 primary after reset, flag 0");
    rd_expect(4'd1, 32'h0000_0006, "R5 R6 secondary after reset");
    chk(locked === 6'h2F, "R7 OR of fields", 32'(locked), 32'h2F);
    op_expect(3'd4, 1, "R8 unlocked block granted");
    op_expect(3'd0, 0, "R8 primary-locked block refused");
    op_expect(3'd1, 0, "R8 secondary-locked block refused");
    op_expect(3'd6, 0, "R8 out-of-range index refused");
    wr_reg(4'd0, 32'h0000_0000);
    rd_expect(4'd0, 32'h0000_0029, "R3 write ignored while locked");
    wr_reg(4'd0, KEY ^ 32'h1);
    rd_expect(4'd0, 32'h0000_0029, "R3 wrong key no effect");
    wr_reg(4'd2, KEY);
    rd_expect(4'd0, 32'h0000_0029, "R2 key at other address does not unlock");
    wr_reg(4'd1, 32'hFFFF_FFC0);
    rd_expect(4'd1, 32'h0000_0000, "R6 secondary written without key");
    chk(locked === 6'h29, "R7 after secondary cleared", 32'(locked), 32'h29);
    wr_reg(4'd0, KEY);
    rd_expect(4'd0, 32'h8000_0029, "R2 R4 key sets flag, field kept");
    wr_reg(4'd0, 32'h0000_0010);
    rd_expect(4'd0, 32'h8000_0010, "R3 write after unlock");
    wr_reg(4'd0, KEY);
    rd_expect(4'd0, 32'h8000_0010, "R4 repeated key leaves field");
    wr_reg(4'd0, 32'h7FFF_FFC0);
    rd_expect(4'd0, 32'h8000_0000, "R2 R6 flag not clearable, upper bits zero");
    wr_reg(4'd5, 32'hFFFF_FFFF);
    rd_expect(4'd5, 32'h0000_0000, "R9 unmapped read zero");
    rd_expect(4'd0, 32'h8000_0000, "R9 unmapped write ignored");
    repeat (3) idle();
    chk(rdata === 32'h8000_0000, "R9 rdata holds", rdata, 32'h8000_0000);
    op_expect(3'd0, 1, "R8 block granted after unlock");

    do_reset(6'h3F, 6'h3F);
    rd_expect(4'd0, 32'h0000_003F, "R2 R5 flag cleared, erased shadow locks");
    op_expect(3'd2, 0, "R5 R8 erased shadow refuses");
    wr_reg(4'd0, KEY);
    wr_reg(4'd0, 32'h0);
    wr_reg(4'd1, 32'h0);
    idle();
    chk(locked === 6'h00, "R3 R7 all unlocked", 32'(locked), 32'h0);

    for (int i = 0; i < 2000; i++) begin
      logic [31:0] d;
      d = ($urandom % 5 == 0) ? KEY : $urandom;
      drive($urandom % 3 == 0, $urandom % 2 == 0, ($urandom % 8 == 0) ? 4'(4'd8 + $urandom % 8) : 4'($urandom % 3),
            d, $urandom % 2 == 0, 3'($urandom % 8));
    end
    idle();
    idle();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule